// File: doc/BRIEF.md
# Repeat-Compressed Test Vector Player

This block replays a stored test pattern onto a group of device pins, one vector per cycle. Each stored line holds a drive word, an expected-response word, a per-pin compare enable, a repeat count and an end marker. A line with repeat count N occupies N+1 consecutive cycles. A long quiet stretch, or a return-to-zero clock kept as a constant "on" bit, therefore costs one memory line rather than one line per cycle. Shaping that bit into a real clock edge happens outside the block.

Lines are written through a simple write port while the player is idle. A start pulse plays the lines from address 0 with no gap between them. On every playing cycle the block compares the sampled device response against the expected word, looking only at pins whose enable bit is set. Any mismatch raises a sticky fail flag and records the absolute cycle number of the first mismatch. Playback ends after the line carrying the end marker, or after the top address of the memory, and a one-cycle done pulse follows.

Top module: `vec_player`

## Requirements
- R1: After reset, `pin_out`, `active`, `done`, `fail` and `first_fail_cyc` are all zero.
- R2: Start is taken while idle at edge E. `active` rises and the drive word of line 0 appears on `pin_out` at edge E+2.
- R3: A line with repeat field N holds its drive word on `pin_out` with `active` high for exactly N+1 consecutive cycles. Repeat 0 gives one cycle and repeat 999 gives 1000 cycles.
- R4: Lines play in ascending address order with no idle cycle between them. A run-length-compressed list and its one-line-per-cycle equivalent produce the same cycle-by-cycle pin stream.
- R5: Playback ends after the line whose end marker is set, or after line DEPTH-1 if no marker is met first. In the cycle after the final vector, `active` is low, `pin_out` is zero and `done` is high for exactly one cycle.
- R6: In a playing cycle, the response on `dut_in` is sampled at the closing clock edge. It counts as a mismatch when any pin whose compare-enable bit is 1 differs from the expected word. Pins whose enable bit is 0 never cause a mismatch, and nothing is compared while idle.
- R7: `fail` stays set until the next accepted start, which clears it. `first_fail_cyc` holds the 0-based cycle index, counted from the first vector of the run, of the first mismatch. Later mismatches in the same run leave it unchanged.
- R8: While a playback is in progress, a start pulse and writes to the vector memory are ignored. The running pattern and the stored lines are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin playback at line 0 (taken only while idle) |
| wr_en | input | 1 | Write one line into the vector memory |
| wr_addr | input | $clog2(DEPTH) | Line address for the write |
| wr_drive | input | PIN_W | Drive word for the line |
| wr_expect | input | PIN_W | Expected response word for the line |
| wr_mask | input | PIN_W | Per-pin compare enable, 1 = compare |
| wr_rep | input | REP_W | Repeat count N; the line lasts N+1 cycles |
| wr_last | input | 1 | End marker: playback stops after this line |
| dut_in | input | PIN_W | Sampled device response |
| pin_out | output | PIN_W | Drive word of the current cycle, zero when idle |
| active | output | 1 | High on every cycle that carries a vector |
| done | output | 1 | One-cycle pulse after the final vector |
| fail | output | 1 | Sticky mismatch flag |
| first_fail_cyc | output | CYC_W | Cycle index of the first mismatch |

## Verification
A wrong repeat counter or a wrong read pointer shows in the captured pin stream. A line becomes longer, shorter or repeated, and the stream breaks at that cycle, well before `done`. A miscounted cycle index or a fail flag that is not sticky shows in the fail outputs read at the end of a run. Injecting a single-bit error at every cycle position of a 16-cycle pattern pins down an off-by-one error in the first-fail index at its exact position. An end-of-playback fault shows one cycle after the final vector, through the timing and width of `done` and through `pin_out` returning to zero.

// File: rtl/vp_pkg.sv
package vp_pkg;
  typedef enum logic [1:0] {
    VP_IDLE  = 2'd0,
    VP_PRIME = 2'd1,
    VP_PLAY  = 2'd2
  } vp_state_e;
endpackage

// File: rtl/vp_mem.sv
// Simple dual-port line store: one write port, one registered read port.
module vp_mem #(
  parameter int WIDTH = 41,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/vp_seq.sv
// Playback sequencer: one-line lookahead over a registered-read memory,
// expands each line by its repeat count, counts absolute cycles.
module vp_seq
  import vp_pkg::*;
#(
  parameter int PIN_W = 8,
  parameter int DEPTH = 16,
  parameter int REP_W = 16,
  parameter int CYC_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int ENT_W = 3*PIN_W + REP_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ENT_W-1:0] q,
  output logic [AW-1:0]    raddr,
  output logic             busy,
  output logic             launch,
  output logic             active,
  output logic [PIN_W-1:0] drive,
  output logic [PIN_W-1:0] expect_w,
  output logic [PIN_W-1:0] mask,
  output logic [CYC_W-1:0] cyc,
  output logic             done
);
  localparam int DRV_LO = 0;
  localparam int EXP_LO = PIN_W;
  localparam int MSK_LO = 2*PIN_W;
  localparam int REP_LO = 3*PIN_W;
  localparam int LST_B  = 3*PIN_W + REP_W;
  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH-1);

  vp_state_e        state;
  logic [ENT_W-1:0] cur;
  logic [AW-1:0]    cur_addr;
  logic [AW-1:0]    ptr;
  logic [AW-1:0]    ptr_nxt;
  logic [REP_W-1:0] cnt;
  logic             act_q;
  logic             done_q;
  logic [CYC_W-1:0] cyc_q;

  logic [REP_W-1:0] cur_rep;
  logic             cur_last;
  logic             fin;
  logic             at_end;
  logic             adv;

  assign cur_rep  = cur[REP_LO +: REP_W];
  assign cur_last = cur[LST_B];
  assign fin      = (cnt == cur_rep);
  assign at_end   = cur_last || (cur_addr == TOP_ADDR);
  assign launch   = (state == VP_IDLE) && start;
  assign adv      = (state == VP_PRIME) || ((state == VP_PLAY) && fin && !at_end);
  assign ptr_nxt  = (ptr == TOP_ADDR) ? '0 : ptr + 1'b1;

  always_comb begin
    if (state == VP_IDLE) raddr = '0;
    else if (adv)         raddr = ptr_nxt;
    else                  raddr = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= VP_IDLE;
      cur      <= '0;
      cur_addr <= '0;
      ptr      <= '0;
      cnt      <= '0;
      act_q    <= 1'b0;
      done_q   <= 1'b0;
      cyc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        VP_IDLE: begin
          if (start) begin
            state <= VP_PRIME;
            ptr   <= '0;
            cyc_q <= '0;
          end
        end
        VP_PRIME: begin
          state    <= VP_PLAY;
          cur      <= q;
          cur_addr <= ptr;
          ptr      <= ptr_nxt;
          cnt      <= '0;
          act_q    <= 1'b1;
        end
        VP_PLAY: begin
          cyc_q <= cyc_q + 1'b1;
          if (!fin) begin
            cnt <= cnt + 1'b1;
          end else if (at_end) begin
            state  <= VP_IDLE;
            cur    <= '0;
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cur      <= q;
            cur_addr <= ptr;
            ptr      <= ptr_nxt;
            cnt      <= '0;
          end
        end
        default: state <= VP_IDLE;
      endcase
    end
  end

  assign busy     = (state != VP_IDLE);
  assign active   = act_q;
  assign drive    = cur[DRV_LO +: PIN_W];
  assign expect_w = cur[EXP_LO +: PIN_W];
  assign mask     = cur[MSK_LO +: PIN_W];
  assign cyc      = cyc_q;
  assign done     = done_q;
endmodule

// File: rtl/vp_cmp.sv
// Masked response compare with sticky fail and first-fail cycle capture.
module vp_cmp #(
  parameter int PIN_W = 8,
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             active,
  input  logic [PIN_W-1:0] expect_w,
  input  logic [PIN_W-1:0] mask,
  input  logic [PIN_W-1:0] dut_in,
  input  logic [CYC_W-1:0] cyc,
  output logic             fail,
  output logic [CYC_W-1:0] first_cyc
);
  logic mism;
  assign mism = |((dut_in ^ expect_w) & mask);

  always_ff @(posedge clk) begin
    if (rst || launch) begin
      fail      <= 1'b0;
      first_cyc <= '0;
    end else if (active && mism && !fail) begin
      fail      <= 1'b1;
      first_cyc <= cyc;
    end
  end
endmodule

// File: rtl/vec_player.sv
module vec_player #(
  parameter int PIN_W = 8,
  parameter int DEPTH = 16,
  parameter int REP_W = 16,
  parameter int CYC_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIN_W-1:0] wr_drive,
  input  logic [PIN_W-1:0] wr_expect,
  input  logic [PIN_W-1:0] wr_mask,
  input  logic [REP_W-1:0] wr_rep,
  input  logic             wr_last,
  input  logic [PIN_W-1:0] dut_in,
  output logic [PIN_W-1:0] pin_out,
  output logic             active,
  output logic             done,
  output logic             fail,
  output logic [CYC_W-1:0] first_fail_cyc
);
  localparam int ENT_W = 3*PIN_W + REP_W + 1;

  logic [ENT_W-1:0] wdata;
  logic [ENT_W-1:0] q;
  logic [AW-1:0]    raddr;
  logic             busy;
  logic             launch;
  logic [PIN_W-1:0] expect_w;
  logic [PIN_W-1:0] mask;
  logic [CYC_W-1:0] cyc;
  logic             we;

  assign wdata = {wr_last, wr_rep, wr_mask, wr_expect, wr_drive};
  assign we    = wr_en && !busy;

  vp_mem #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(we), .waddr(wr_addr), .wdata(wdata),
    .raddr(raddr), .rdata(q)
  );

  vp_seq #(.PIN_W(PIN_W), .DEPTH(DEPTH), .REP_W(REP_W), .CYC_W(CYC_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .q(q), .raddr(raddr),
    .busy(busy), .launch(launch), .active(active), .drive(pin_out),
    .expect_w(expect_w), .mask(mask), .cyc(cyc), .done(done)
  );

  vp_cmp #(.PIN_W(PIN_W), .CYC_W(CYC_W)) u_cmp (
    .clk(clk), .rst(rst), .launch(launch), .active(active),
    .expect_w(expect_w), .mask(mask), .dut_in(dut_in), .cyc(cyc),
    .fail(fail), .first_cyc(first_fail_cyc)
  );
endmodule

// File: rtl/vp_checker.sv
module vp_checker #(
  parameter int PIN_W = 8,
  parameter int CYC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [PIN_W-1:0] pin_out,
  input logic             active,
  input logic             done,
  input logic             fail,
  input logic [CYC_W-1:0] first_fail_cyc
);
  AST_START_TO_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(start, 2)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_DONE_AFTER_PLAY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!active && $past(active))); // R5

  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
    !active |-> (pin_out == '0)); // R5

  AST_FAIL_ONLY_PLAYING: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(active)); // R6

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && !(start && !active)) |=> fail); // R7

  AST_FIRST_FAIL_HELD: assert property (@(posedge clk) disable iff (rst)
    (fail && !(start && !active)) |=> $stable(first_fail_cyc)); // R7
endmodule

bind vec_player vp_checker #(.PIN_W(PIN_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .pin_out(pin_out), .active(active),
  .done(done), .fail(fail), .first_fail_cyc(first_fail_cyc)
);

// File: tb/tb_vec_player.sv
module tb_vec_player;
  localparam int PIN_W = 8;
  localparam int DEPTH = 16;
  localparam int REP_W = 16;
  localparam int CYC_W = 32;
  localparam int AW    = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst, start, wr_en, wr_last;
  logic [AW-1:0]    wr_addr;
  logic [PIN_W-1:0] wr_drive, wr_expect, wr_mask, dut_in, pin_out;
  logic [REP_W-1:0] wr_rep;
  logic             active, done, fail;
  logic [CYC_W-1:0] first_fail_cyc;

  logic             inj_now;
  logic [PIN_W-1:0] inj_bits;
  int               inj_k, inj_k2;

  assign dut_in = pin_out ^ (inj_now ? inj_bits : 8'h00);

  vec_player #(.PIN_W(PIN_W), .DEPTH(DEPTH), .REP_W(REP_W), .CYC_W(CYC_W)) dut (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_drive(wr_drive), .wr_expect(wr_expect), .wr_mask(wr_mask),
    .wr_rep(wr_rep), .wr_last(wr_last), .dut_in(dut_in), .pin_out(pin_out),
    .active(active), .done(done), .fail(fail), .first_fail_cyc(first_fail_cyc)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] stream [64];
  logic [7:0] ref_s  [16];
  int n_rec, lat;
  bit done_ok, done_short, pins_zero;

  int lens [6] = '{1, 3, 1, 5, 2, 4};

  function automatic logic [7:0] runval(int r);
    return 8'h5A ^ 8'(r * 8'h33);
  endfunction

  function automatic logic [7:0] expv(int j);
    int acc = 0;
    for (int r = 0; r < 6; r++) begin
      acc += lens[r];
      if (j < acc) return runval(r);
    end
    return 8'h00;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(int a, logic [7:0] d, logic [7:0] m, int rep, bit last);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_drive = d; wr_expect = d;
    wr_mask = m; wr_rep = REP_W'(rep); wr_last = last;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_flat();
    for (int i = 0; i < 16; i++) put(i, expv(i), 8'hFF, 0, 1'b0);
  endtask

  task automatic load_packed(logic [7:0] m);
    for (int r = 0; r < 6; r++) put(r, runval(r), m, lens[r] - 1, r == 5);
  endtask

  // Plays the stored pattern, recording pins; optional disturbance mid-run.
  task automatic play(bit disturb);
    int k;
    bit prev_act;
    n_rec = 0; lat = 0; done_ok = 0; done_short = 0; pins_zero = 0;
    inj_now = 1'b0; prev_act = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 1;
    while (k < 5000) begin
      wr_en = 1'b0; start = 1'b0;
      if (active) begin
        if (lat == 0) lat = k;
        if (n_rec < 64) stream[n_rec] = pin_out;
        inj_now = (n_rec == inj_k) || (n_rec == inj_k2);
        n_rec++;
        if (disturb && n_rec == 3) begin
          wr_en = 1'b1; wr_addr = 4'd2; wr_drive = 8'hFF; wr_expect = 8'hFF;
          wr_mask = 8'hFF; wr_rep = 16'd7; wr_last = 1'b0; start = 1'b1;
        end
      end else begin
        inj_now = 1'b0;
        if (done) begin
          done_ok   = prev_act;
          pins_zero = (pin_out == 8'h00);
          @(negedge clk);
          done_short = !done;
          break;
        end
      end
      prev_act = active;
      @(negedge clk);
      k++;
    end
    if (k >= 5000) chk("R5", "playback never finished", 0, 1);
  endtask

  function automatic int mism_flat();
    int bad = 0;
    for (int j = 0; j < 16; j++) if (stream[j] != expv(j)) bad++;
    return bad;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_drive = '0;
    wr_expect = '0; wr_mask = '0; wr_rep = '0; wr_last = 1'b0;
    inj_k = -1; inj_k2 = -1; inj_bits = 8'h01; inj_now = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "pin_out after reset", pin_out, 0);
    chk("R1", "active after reset", active, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "fail after reset", fail, 0);
    chk("R1", "first_fail_cyc after reset", first_fail_cyc, 0);

    // One line per cycle, no end marker: stops after the top address.
    load_flat();
    play(1'b0);
    chk("R2", "start-to-first-vector latency", lat, 2);
    chk("R5", "flat list length", n_rec, 16);
    chk("R4", "flat stream mismatches", mism_flat(), 0);
    chk("R5", "done right after last vector", done_ok, 1);
    chk("R5", "done single cycle", done_short, 1);
    chk("R5", "pins zero at done", pins_zero, 1);
    chk("R6", "no fail on clean flat run", fail, 0);
    for (int j = 0; j < 16; j++) ref_s[j] = stream[j];

    // Run-length compressed equivalent, disturbed mid-run.
    load_packed(8'hFF);
    play(1'b1);
    chk("R3", "compressed list length", n_rec, 16);
    begin
      int bad = 0;
      for (int j = 0; j < 16; j++) if (stream[j] != ref_s[j]) bad++;
      chk("R4", "compressed vs flat stream mismatches", bad, 0);
    end
    chk("R8", "stream unchanged by write/start while playing", mism_flat(), 0);
    play(1'b0);
    chk("R8", "replay after ignored write: length", n_rec, 16);
    chk("R8", "replay after ignored write: mismatches", mism_flat(), 0);

    // Single-bit error swept over every cycle position.
    inj_bits = 8'h01;
    for (int k = 0; k < 16; k++) begin
      inj_k = k;
      play(1'b0);
      chk("R6", $sformatf("fail with error at cycle %0d", k), fail, 1);
      chk("R7", $sformatf("first fail index for cycle %0d", k), first_fail_cyc, k);
    end
    inj_k = 4; inj_k2 = 9;
    play(1'b0);
    chk("R7", "first of two failures kept", first_fail_cyc, 4);
    chk("R7", "fail held until end of run", fail, 1);
    inj_k = -1; inj_k2 = -1;
    @(negedge clk);
    chk("R7", "fail still set while idle", fail, 1);
    play(1'b0);
    chk("R7", "fail cleared by next start", fail, 0);
    chk("R7", "first_fail_cyc cleared by next start", first_fail_cyc, 0);

    // Compare mask: only low nibble compared.
    load_packed(8'h0F);
    inj_bits = 8'hF0; inj_k = 2; inj_k2 = 10;
    play(1'b0);
    chk("R6", "masked pins cause no fail", fail, 0);
    inj_bits = 8'h08; inj_k = 3; inj_k2 = -1;
    play(1'b0);
    chk("R6", "compared pin causes fail", fail, 1);
    chk("R7", "first fail on masked pattern", first_fail_cyc, 3);
    inj_k = -1;

    // Repeat extremes.
    put(0, 8'hC3, 8'hFF, 999, 1'b1);
    play(1'b0);
    chk("R3", "repeat 999 length", n_rec, 1000);
    chk("R3", "repeat 999 data", stream[63], 8'hC3);
    chk("R5", "done after long line", done_ok, 1);
    put(0, 8'h3C, 8'hFF, 0, 1'b1);
    play(1'b0);
    chk("R3", "repeat 0 length", n_rec, 1);
    chk("R3", "repeat 0 data", stream[0], 8'h3C);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule